// File: doc/BRIEF.md
# Two-Vector Scan Delay Test Sequencer

This block sequences a two-vector delay test on a plain multiplexed scan chain that has no hold latches. It drives the chain's scan enable and a one-cycle clock-enable strobe for each chain clock. A companion strobe marks the pulses that must use the rated period. It does not make clocks: it runs from one fast free-running clock, and a slow chain clock is one strobe every `SLOW_DIV` cycles.

A run starts on `start`. The first vector is shifted in with slow strobes. The second vector is then launched in one of two ways, chosen by `launch_mode`:
- By one more scan shift (mode 0).
- By one functional clock with scan enable low (mode 1).

The capture strobe follows the launch strobe after exactly one fast cycle, which is the rated period. The captured response is then shifted out with slow strobes, and `done` is raised. `pi_v2_sel` tells the pin driver when to present the second set of primary-input values.

Top module: `scan_delay_ctrl`

## Requirements
In all timing below, `start` is sampled at clock edge 0, "cycle n" means the cycle after edge n, L = `CHAIN_LEN` and S = `SLOW_DIV`.

- R1: After a synchronous reset, `scan_en`, `chain_ce`, `rated_sel`, `pi_v2_sel`, `busy` and `done` are all 0.
- R2: The load phase strobes `chain_ce` in cycles S, 2S, … L·S, with `scan_en` = 1 from cycle 1 through cycle L·S.
- R3: The launch strobe comes in cycle (L+1)·S. In mode 0, `scan_en` stays 1 from L·S+1 through the launch cycle.
- R4: The capture strobe comes in cycle (L+1)·S+1, exactly one cycle after launch, with `scan_en` = 0.
- R5: In mode 1, `scan_en` is 0 from cycle L·S+1 through the capture cycle, so launch happens in functional mode.
- R6: `pi_v2_sel` is 1 exactly in the launch and capture cycles.
- R7: The unload phase strobes `chain_ce` in cycles (L+1)·S+1+k·S for k = 1..L. `scan_en` is 1 from (L+1)·S+2 through (2L+1)·S+1, and 0 in idle.
- R8: `busy` is 1 in cycles 1 through (2L+1)·S+1. `done` is 1 from cycle (2L+1)·S+2 and stays 1 until the next accepted `start`.
- R9: `start` is ignored while `busy` is 1.
- R10: `launch_mode` is sampled only with an accepted `start`; changing it mid-run has no effect.
- R11: `rated_sel` is 1 only in the launch and capture cycles. Every other `chain_ce` strobe is slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period is the rated period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when not busy) |
| launch_mode | input | 1 | 0 = launch by extra shift, 1 = launch by functional clock |
| scan_en | output | 1 | Chain scan enable (1 = shift) |
| chain_ce | output | 1 | One-cycle chain clock-enable strobe |
| rated_sel | output | 1 | Marks launch and capture strobes (rated timing) |
| pi_v2_sel | output | 1 | Present second-vector primary inputs |
| busy | output | 1 | Run in progress |
| done | output | 1 | Unload finished; held until next start |

## Verification
Two cases can fall in the same cycle.

First, a new `start` arrives while `done` from the previous run is still held. Runs are issued back to back to provoke this, and the bench expects `done` low and `busy` high from cycle 1 of the new run.

Second, a mid-run `start` pulse and a mid-run change of `launch_mode` are issued during the load phase. The full cycle-by-cycle output trace must equal the trace the bench predicts for an undisturbed run in the originally sampled mode.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PREP,
    ST_CAPTURE,
    ST_UNLOAD,
    ST_FINISH
  } sdc_state_t;

  localparam logic LAUNCH_SHIFT = 1'b0;
  localparam logic LAUNCH_FUNC  = 1'b1;
endpackage

// File: rtl/sdc_slow_tick.sv
module sdc_slow_tick #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/sdc_bit_ctr.sv
module sdc_bit_ctr #(
  parameter int CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(CHAIN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST);
endmodule

// File: rtl/scan_delay_ctrl.sv
module scan_delay_ctrl
  import sdc_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int SLOW_DIV  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic launch_mode,
  output logic scan_en,
  output logic chain_ce,
  output logic rated_sel,
  output logic pi_v2_sel,
  output logic busy,
  output logic done
);
  sdc_state_t state;
  logic mode_q, se_q, ce_q, rated_q, v2_q, busy_q, done_q;
  logic tick, last_bit, div_clr, ctr_clr, ctr_inc;

  assign div_clr = (state == ST_IDLE) || (state == ST_CAPTURE) || (state == ST_FINISH);
  assign ctr_clr = (state == ST_IDLE) || (state == ST_PREP) || (state == ST_CAPTURE);
  assign ctr_inc = tick && ((state == ST_LOAD) || (state == ST_UNLOAD));

  sdc_slow_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(div_clr), .tick(tick)
  );

  sdc_bit_ctr #(.CHAIN_LEN(CHAIN_LEN)) u_bits (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(ctr_inc), .last(last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= LAUNCH_SHIFT;
      se_q    <= 1'b0;
      ce_q    <= 1'b0;
      rated_q <= 1'b0;
      v2_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ce_q    <= 1'b0;
      rated_q <= 1'b0;
      v2_q    <= 1'b0;
      case (state)
        ST_IDLE: begin
          se_q <= 1'b0;
          if (start) begin
            state  <= ST_LOAD;
            mode_q <= launch_mode;
            se_q   <= 1'b1;
            busy_q <= 1'b1;
            done_q <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (tick) begin
            ce_q <= 1'b1;
            if (last_bit) state <= ST_PREP;
          end
        end
        ST_PREP: begin
          // Functional launch needs scan enable low one slow period ahead.
          se_q <= (mode_q == LAUNCH_SHIFT);
          if (tick) begin
            ce_q    <= 1'b1;
            rated_q <= 1'b1;
            v2_q    <= 1'b1;
            state   <= ST_CAPTURE;
          end
        end
        ST_CAPTURE: begin
          ce_q    <= 1'b1;
          rated_q <= 1'b1;
          v2_q    <= 1'b1;
          se_q    <= 1'b0;
          state   <= ST_UNLOAD;
        end
        ST_UNLOAD: begin
          se_q <= 1'b1;
          if (tick) begin
            ce_q <= 1'b1;
            if (last_bit) state <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          se_q   <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scan_en   = se_q;
  assign chain_ce  = ce_q;
  assign rated_sel = rated_q;
  assign pi_v2_sel = v2_q;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/scan_delay_ctrl_chk.sv
module scan_delay_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic scan_en,
  input logic chain_ce,
  input logic rated_sel,
  input logic pi_v2_sel,
  input logic busy,
  input logic done
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !busy && !done && !chain_ce && !scan_en);

  a_r4_capture_after_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(rated_sel) |=> rated_sel && chain_ce && !scan_en);

  a_r11_rated_pair_only: assert property (@(posedge clk) disable iff (rst)
    (rated_sel && $past(rated_sel)) |=> !rated_sel);

  a_r11_rated_needs_ce: assert property (@(posedge clk) disable iff (rst)
    rated_sel |-> chain_ce);

  a_r6_v2_in_rated_window: assert property (@(posedge clk) disable iff (rst)
    pi_v2_sel |-> rated_sel && busy);

  a_r8_done_excludes_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_done_held: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

bind scan_delay_ctrl scan_delay_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .scan_en(scan_en),
  .chain_ce(chain_ce), .rated_sel(rated_sel), .pi_v2_sel(pi_v2_sel),
  .busy(busy), .done(done)
);

// File: tb/scan_delay_ctrl_tb_top.sv
module scan_delay_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;
  localparam int S = 3;
  localparam int T_DONE = (2*L+1)*S + 2;
  localparam int T_LAUNCH = (L+1)*S;
  localparam int WATCHDOG = 200000;

  // row: {mode, toggle mode mid-run, extra start mid-run}
  localparam logic [2:0] RUNS [6] = '{3'b000, 3'b100, 3'b011, 3'b111, 3'b001, 3'b110};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, launch_mode = 1'b0;
  logic scan_en, chain_ce, rated_sel, pi_v2_sel, busy, done;
  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_delay_ctrl #(.CHAIN_LEN(L), .SLOW_DIV(S)) dut_i (
    .clk(clk), .rst(rst), .start(start), .launch_mode(launch_mode),
    .scan_en(scan_en), .chain_ce(chain_ce), .rated_sel(rated_sel),
    .pi_v2_sel(pi_v2_sel), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int n,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s cycle %0d act=%0b exp=%0b", tag, what, n, act, exp);
    end
  endtask

  function automatic string phase_tag(input int n, input logic m);
    if (n <= L*S) return "R2";
    if (n <= T_LAUNCH) return m ? "R5" : "R3";
    if (n == T_LAUNCH + 1) return "R4";
    if (n <= T_DONE - 1) return "R7";
    return "R8";
  endfunction

  task automatic run(input logic m, input logic tog, input logic extra);
    @(negedge clk);
    launch_mode = m;
    start = 1'b1;
    @(negedge clk);           // after edge 0
    start = 1'b0;
    for (int n = 1; n <= T_DONE + 2; n++) begin
      logic e_load, e_unl, e_rated, e_ce, e_se;
      string tg;
      @(negedge clk);
      e_load  = (n % S == 0) && (n / S >= 1) && (n / S <= L);
      e_unl   = (n > T_LAUNCH + 1) && ((n - T_LAUNCH - 1) % S == 0)
                && ((n - T_LAUNCH - 1) / S <= L);
      e_rated = (n == T_LAUNCH) || (n == T_LAUNCH + 1);
      e_ce    = e_load || e_unl || e_rated;
      if (n <= L*S) e_se = 1'b1;
      else if (n <= T_LAUNCH) e_se = !m;
      else if (n == T_LAUNCH + 1) e_se = 1'b0;
      else if (n <= T_DONE - 1) e_se = 1'b1;
      else e_se = 1'b0;
      tg = phase_tag(n, m);
      chk(tg, "chain_ce", n, chain_ce, e_ce);
      chk(tg, "scan_en", n, scan_en, e_se);
      chk("R6", "pi_v2_sel", n, pi_v2_sel, e_rated);
      chk("R11", "rated_sel", n, rated_sel, e_rated);
      chk(extra ? "R9" : "R8", "busy", n, busy, n <= T_DONE - 1);
      chk(tog ? "R10" : "R8", "done", n, done, n >= T_DONE);
      if (tog && n == 5) launch_mode = !m;
      start = (extra && (n == 7 || n == T_LAUNCH)) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "scan_en", 0, scan_en, 1'b0);
    chk("R1", "chain_ce", 0, chain_ce, 1'b0);
    chk("R1", "rated_sel", 0, rated_sel, 1'b0);
    chk("R1", "pi_v2_sel", 0, pi_v2_sel, 1'b0);
    chk("R1", "busy", 0, busy, 1'b0);
    chk("R1", "done", 0, done, 1'b0);

    for (int r = 0; r < 6; r++) run(RUNS[r][2], RUNS[r][1], RUNS[r][0]);

    // Reset in the middle of a run returns to the quiet state (R1).
    @(negedge clk);
    launch_mode = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (T_LAUNCH - 1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "busy after mid reset", 0, busy, 1'b0);
    chk("R1", "done after mid reset", 0, done, 1'b0);
    chk("R1", "scan_en after mid reset", 0, scan_en, 1'b0);
    chk("R1", "rated_sel after mid reset", 0, rated_sel, 1'b0);

    // A fresh run after the reset still follows the timeline.
    run(1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule